// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits next to an 8-bit microcontroller core and decides which of fifteen interrupt sources is presented to it. Every source has its own enable bit and a two-bit priority level. The level is built from one bit in a priority register and one bit in a priority-high register. A global enable gates all sources at once. The controller keeps a four-bit in-service mask with one bit per level. A request at a strictly higher level than any level in service preempts the running handler. Requests at an equal or lower level wait. When the core signals a return, the most recent, highest level is retired and the preempted level carries on.

Six sources are request lines from peripherals outside the block. The remaining nine are flags held inside the block: an ADC-done flag, four capture flags, three compare-match flags, and two overflow flags (8-bit and 16-bit) that share one source through an OR. Hardware never clears these flags, so an uncleared flag raises its request again. Software can set or clear all of them through a small byte-wide register port, except the ADC-done flag, which software may only clear. The core reads a registered request, a 4-bit source index and a 2-bit level. It answers with a one-cycle acknowledge and, at the end of the handler, a one-cycle return strobe.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A source's level is {priority-high bit, priority bit}. 3 is the highest level and 0 the lowest. The presented request is always the eligible one at the highest level, even when its source index is larger.
- R2: When several eligible sources share the winning level, the lowest source index is presented.
- R3: A source is eligible only when its enable bit and the global enable are both 1. With the global enable at 0, irq_req stays low whatever else is set.
- R4: A pending source is not presented while a level equal to or above its own is in service. It is presented once that level has been returned.
- R5: A source whose level is strictly above the highest in-service level is presented, and acknowledging it adds its level to the mask without removing the lower level.
- R6: irq_ack while irq_req is high sets mask bit irq_lvl on that edge and drops irq_req on that same edge. The arbitration is then re-evaluated against the new mask.
- R7: irq_ret clears only the highest set bit of isr_mask.
- R8: Source 14 is requested when either overflow flag is set: the 8-bit flag at address 6 bit 7 or the 16-bit flag at address 7 bit 0.
- R9: Hardware never clears the timer flags or the ADC-done flag. A flag left set is presented again after its handler returns.
- R10: The ADC-done flag (source 6, address 7 bit 1) is cleared by writing 0 and cannot be set by writing 1. Only hw_adc_set sets it.
- R11: The capture flags (address 6 bits 0..3, sources 7..10) and compare flags (address 6 bits 4..6, sources 11..13) are set and cleared by writes, with the same effect as hardware.
- R12: A hardware set of a flag in the same cycle as a write that clears it leaves the flag set.
- R13: Register map, byte-wide, reads return the stored values:
  - address 0: bit 7 is the global enable and bits 6..0 are the enables of sources 6..0 (ADC, I2C serial, UART serial, timer 1, external 1, timer 0, external 0).
  - address 1: enables of sources 14..7.
  - addresses 2 and 3: priority bits of sources 6..0 and 14..7.
  - addresses 4 and 5: priority-high bits in the same layout.
  - Everything resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| src_line | input | 6 | Request lines of sources 0..5 |
| hw_tmr_set | input | 9 | Hardware set pulses: capture 0..3, compare 0..2, 8-bit overflow, 16-bit overflow |
| hw_adc_set | input | 1 | Hardware set pulse of the ADC-done flag |
| irq_req | output | 1 | Request presented to the core |
| irq_idx | output | 4 | Source index of the request |
| irq_lvl | output | 2 | Level of the request |
| irq_ack | input | 1 | Core accepts the request |
| irq_ret | input | 1 | Core returns from the current handler |
| isr_mask | output | 4 | In-service mask, one bit per level |

## Verification
The bench checks a level-0 request that is held back while level 0 is in service, and a level-3 request that preempts it. A design that compared levels with greater-or-equal would nest a handler inside itself. One that did not gate on the mask would never hold the request back. Returning twice must retire level 3 first and only then release the waiting source, so a return that cleared the lowest bit shows up at once. The bench also tries to set the ADC-done flag from software, and it clears a flag in the same cycle as a hardware set: a plain register would accept the first and lose the hardware event in the second. It lets an uncleared compare flag re-request after return, and it drives each overflow flag alone onto the shared source.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC  = 15;
  localparam int NLVL  = 4;
  localparam int LVLW  = 2;
  localparam int IDXW  = 4;
  localparam int NLINE = 6;
  localparam int NTMR  = 9;
  typedef logic [LVLW-1:0] lvl_t;
  typedef logic [IDXW-1:0] idx_t;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [NLINE-1:0] line_i,
  input  logic [NTMR-1:0]  hw_tmr_i,
  input  logic             hw_adc_i,
  output logic [NSRC-1:0]  pend_o,
  output lvl_t             lvl_o [NSRC],
  output logic             gie_o
);
  localparam int LOW  = 7;            // sources held in the low byte
  localparam int HIGH = NSRC - LOW;   // sources held in the high byte
  localparam int ADC_SRC = NLINE;
  localparam int TMR_SRC = NLINE + 1;
  localparam int NCAPCMP = NTMR - 2;

  logic [NSRC-1:0] en_q, en_d, pri_q, pri_d, prh_q, prh_d;
  logic            gie_q, gie_d;
  logic [NTMR-1:0] tmr_q, tmr_d, tmr_sw;
  logic            adc_q, adc_d, adc_sw;
  logic [NSRC-1:0] raw;

  // next-state
  always_comb begin
    en_d   = en_q;
    pri_d  = pri_q;
    prh_d  = prh_q;
    gie_d  = gie_q;
    tmr_sw = tmr_q;
    adc_sw = adc_q;
    if (we) begin
      unique case (addr)
        3'd0: begin gie_d = wdata[7]; en_d[LOW-1:0] = wdata[LOW-1:0]; end
        3'd1: en_d[NSRC-1:LOW]  = wdata[HIGH-1:0];
        3'd2: pri_d[LOW-1:0]    = wdata[LOW-1:0];
        3'd3: pri_d[NSRC-1:LOW] = wdata[HIGH-1:0];
        3'd4: prh_d[LOW-1:0]    = wdata[LOW-1:0];
        3'd5: prh_d[NSRC-1:LOW] = wdata[HIGH-1:0];
        3'd6: tmr_sw[7:0]       = wdata;
        3'd7: begin
          tmr_sw[NTMR-1] = wdata[0];
          adc_sw         = adc_q & wdata[1];   // software may only clear
        end
        default: ;
      endcase
    end
    tmr_d = tmr_sw | hw_tmr_i;   // hardware set wins
    adc_d = adc_sw | hw_adc_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
      prh_q <= '0;
      gie_q <= 1'b0;
      tmr_q <= '0;
      adc_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      pri_q <= pri_d;
      prh_q <= prh_d;
      gie_q <= gie_d;
      tmr_q <= tmr_d;
      adc_q <= adc_d;
    end
  end

  // source assembly
  always_comb begin
    raw = '0;
    raw[NLINE-1:0] = line_i;
    raw[ADC_SRC]   = adc_q;
    raw[TMR_SRC +: NCAPCMP] = tmr_q[NCAPCMP-1:0];
    raw[NSRC-1]    = tmr_q[NTMR-2] | tmr_q[NTMR-1];
  end

  assign pend_o = raw & en_q & {NSRC{gie_q}};
  assign gie_o  = gie_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_lvl
    assign lvl_o[s] = {prh_q[s], pri_q[s]};
  end

  always_comb begin
    unique case (addr)
      3'd0: rdata = {gie_q, en_q[LOW-1:0]};
      3'd1: rdata = en_q[NSRC-1:LOW];
      3'd2: rdata = {1'b0, pri_q[LOW-1:0]};
      3'd3: rdata = pri_q[NSRC-1:LOW];
      3'd4: rdata = {1'b0, prh_q[LOW-1:0]};
      3'd5: rdata = prh_q[NSRC-1:LOW];
      3'd6: rdata = tmr_q[7:0];
      default: rdata = {6'b0, adc_q, tmr_q[NTMR-1]};
    endcase
  end

  // R10: a write of 1 never sets the ADC-done flag
  p_adc_no_sw_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 3'd7 && wdata[1] && !adc_q && !hw_adc_i) |=> !adc_q);

  // R12: every hardware-set flag is set on the next cycle
  p_hw_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_tmr_i) |=> ((tmr_q & $past(hw_tmr_i)) == $past(hw_tmr_i)));
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  lvl_t            lvl_i [NSRC],
  input  logic [LVLW:0]   floor_i,   // lowest level allowed to win
  output logic            hit_o,
  output idx_t            idx_o,
  output lvl_t            lvl_o
);
  logic [NSRC-1:0] at_lvl [NLVL];
  idx_t            first  [NLVL];

  for (genvar l = 0; l < NLVL; l++) begin : g_level
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign at_lvl[l][s] = pend_i[s] && (lvl_i[s] == LVLW'(l));
    end
    always_comb begin
      first[l] = '0;
      for (int s = NSRC - 1; s >= 0; s--)
        if (at_lvl[l][s]) first[l] = IDXW'(s);
    end
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int l = 0; l < NLVL; l++) begin
      if ((|at_lvl[l]) && ((LVLW+1)'(l) >= floor_i)) begin
        hit_o = 1'b1;
        idx_o = first[l];
        lvl_o = LVLW'(l);
      end
    end
  end
endmodule

// File: rtl/irqc_inservice.sv
module irqc_inservice
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_i,
  input  lvl_t            set_lvl_i,
  input  logic            ret_i,
  output logic [NLVL-1:0] mask_o,
  output logic [LVLW:0]   floor_o
);
  logic [NLVL-1:0] mask_q, mask_d, top_oh;

  always_comb begin
    top_oh  = '0;
    floor_o = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (mask_q[l]) begin
        top_oh  = '0;
        top_oh[l] = 1'b1;
        floor_o = (LVLW+1)'(l + 1);
      end
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (ret_i) mask_d = mask_d & ~top_oh;
    if (set_i) mask_d[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  p_ack_sets_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !ret_i) |=> mask_q[$past(set_lvl_i)]);

  p_ret_clears_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !set_i && mask_q != '0) |=>
      ($countones(mask_q) == $countones($past(mask_q)) - 1));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [NLINE-1:0] src_line,
  input  logic [NTMR-1:0]  hw_tmr_set,
  input  logic             hw_adc_set,
  output logic             irq_req,
  output logic [IDXW-1:0]  irq_idx,
  output logic [LVLW-1:0]  irq_lvl,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic [NLVL-1:0]  isr_mask
);
  logic [NSRC-1:0] pend;
  lvl_t            lvl [NSRC];
  logic            gie;
  logic [LVLW:0]   floor_lvl;
  logic            hit;
  idx_t            win_idx;
  lvl_t            win_lvl;
  logic            ack_ok;
  logic            req_q, req_d;
  idx_t            idx_q, idx_d;
  lvl_t            lvl_q, lvl_d;

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .line_i(src_line), .hw_tmr_i(hw_tmr_set),
    .hw_adc_i(hw_adc_set), .pend_o(pend), .lvl_o(lvl), .gie_o(gie)
  );

  irqc_arb u_arb (
    .pend_i(pend), .lvl_i(lvl), .floor_i(floor_lvl),
    .hit_o(hit), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  assign ack_ok = irq_ack & req_q;

  irqc_inservice u_isr (
    .clk(clk), .rst_n(rst_n), .set_i(ack_ok), .set_lvl_i(lvl_q),
    .ret_i(irq_ret), .mask_o(isr_mask), .floor_o(floor_lvl)
  );

  always_comb begin
    req_d = hit & ~ack_ok;
    idx_d = win_idx;
    lvl_d = win_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
    end else begin
      req_q <= req_d;
      idx_q <= idx_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq_req = req_q;
  assign irq_idx = idx_q;
  assign irq_lvl = lvl_q;

  // R4/R5: a presented request is strictly above every level in service
  p_req_above_isr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((LVLW+1)'(irq_lvl) >= floor_lvl));

  // R3: no request unless the global enable was on
  p_global_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(gie));

  // R6: an accepted request is withdrawn on the next cycle
  p_ack_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !irq_req);
endmodule

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] src_line = '0;
  logic [8:0] hw_tmr_set = '0;
  logic       hw_adc_set = 1'b0;
  logic       irq_req;
  logic [3:0] irq_idx;
  logic [1:0] irq_lvl;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic [3:0] isr_mask;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_nest_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_line(src_line),
    .hw_tmr_set(hw_tmr_set), .hw_adc_set(hw_adc_set), .irq_req(irq_req),
    .irq_idx(irq_idx), .irq_lvl(irq_lvl), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .isr_mask(isr_mask)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(posedge clk); #1 irq_ack = 1'b0;
  endtask

  task automatic pulse_ret();
    @(negedge clk); irq_ret = 1'b1;
    @(posedge clk); #1 irq_ret = 1'b0;
  endtask

  task automatic expect_req(input string tag, input int idx, input int lvl);
    settle();
    chk({tag, " req"}, irq_req, 1);
    chk({tag, " idx"}, irq_idx, idx);
    chk({tag, " lvl"}, irq_lvl, lvl);
  endtask

  task automatic expect_idle(input string tag);
    settle();
    chk({tag, " no req"}, irq_req, 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R13 reset req", irq_req, 0);
    chk("R13 reset mask", isr_mask, 0);
    rd(3'd0, d); chk("R13 reset en", d, 0);
  endtask

  task automatic t_gating();
    src_line = 6'b000001;
    wr(3'd0, 8'h01);
    expect_idle("R3 global off");
    wr(3'd0, 8'h81);
    expect_req("R3 global on", 0, 0);
    wr(3'd0, 8'h80);
    expect_idle("R3 source disabled");
  endtask

  task automatic t_levels();
    logic [7:0] d;
    src_line = 6'b001001;
    wr(3'd0, 8'h89);
    wr(3'd2, 8'h08);
    expect_req("R1 lvl1 beats lvl0", 3, 1);
    wr(3'd4, 8'h01);
    expect_req("R1 lvl2 beats lvl1", 0, 2);
    rd(3'd2, d); chk("R13 pri readback", d, 8'h08);
    wr(3'd2, 8'h00);
    wr(3'd4, 8'h00);
    src_line = 6'b010100;
    wr(3'd0, 8'h94);
    expect_req("R2 lowest index", 2, 0);
  endtask

  task automatic t_nesting();
    pulse_ack();
    chk("R6 ack drops req", irq_req, 0);
    settle();
    chk("R6 mask lvl0", isr_mask, 4'b0001);
    chk("R4 equal level held", irq_req, 0);
    wr(3'd2, 8'h20);
    wr(3'd4, 8'h20);
    wr(3'd0, 8'hB4);
    src_line = 6'b110100;
    expect_req("R5 preempt", 5, 3);
    pulse_ack();
    settle();
    chk("R5 nested mask", isr_mask, 4'b1001);
    src_line = 6'b010100;
    pulse_ret();
    settle();
    chk("R7 top cleared", isr_mask, 4'b0001);
    chk("R4 still held", irq_req, 0);
    pulse_ret();
    expect_req("R4 released", 2, 0);
    chk("R7 mask empty", isr_mask, 0);
    src_line = '0;
    wr(3'd2, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h80);
    expect_idle("cleanup");
  endtask

  task automatic t_overflow();
    wr(3'd1, 8'h80);
    wr(3'd7, 8'h01);
    expect_req("R8 16-bit ovf", 14, 0);
    wr(3'd7, 8'h00);
    expect_idle("R8 cleared");
    wr(3'd6, 8'h80);
    expect_req("R8 8-bit ovf", 14, 0);
    wr(3'd6, 8'h00);
    expect_idle("R8 cleared 8");
  endtask

  task automatic t_sw_flags();
    logic [7:0] d;
    wr(3'd1, 8'h01);
    wr(3'd6, 8'h01);
    expect_req("R11 sw set cap0", 7, 0);
    rd(3'd6, d); chk("R11 readback", d, 8'h01);
    wr(3'd6, 8'h00);
    expect_idle("R11 sw clear");
  endtask

  task automatic t_adc();
    logic [7:0] d;
    wr(3'd0, 8'hC0);
    wr(3'd7, 8'h02);
    rd(3'd7, d); chk("R10 sw set ignored", d, 0);
    expect_idle("R10 no req after sw set");
    @(negedge clk); hw_adc_set = 1'b1;
    @(posedge clk); #1 hw_adc_set = 1'b0;
    rd(3'd7, d); chk("R10 hw set", d, 8'h02);
    expect_req("R10 adc req", 6, 0);
    wr(3'd7, 8'h00);
    rd(3'd7, d); chk("R10 sw clear", d, 0);
    wr(3'd0, 8'h80);
  endtask

  task automatic t_persist();
    wr(3'd1, 8'h10);
    @(negedge clk); hw_tmr_set = 9'h010;
    @(posedge clk); #1 hw_tmr_set = '0;
    expect_req("R9 cmp0 req", 11, 0);
    pulse_ack();
    settle();
    chk("R9 in service", irq_req, 0);
    pulse_ret();
    expect_req("R9 flag re-requests", 11, 0);
    wr(3'd6, 8'h00);
    expect_idle("R9 cleared");
  endtask

  task automatic t_collide();
    logic [7:0] d;
    wr(3'd6, 8'h02);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h00; hw_tmr_set = 9'h002;
    @(posedge clk); #1;
    reg_we = 1'b0; hw_tmr_set = '0;
    rd(3'd6, d); chk("R12 hw set beats clear", d, 8'h02);
    wr(3'd6, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    t_reset();
    t_gating();
    t_levels();
    t_nesting();
    t_overflow();
    t_sw_flags();
    t_adc();
    t_persist();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule